// File: doc/BRIEF.md
# Modem Status Register with Change Detect

This block is the read-only status word of a serial port's modem interface. Four active-low control lines come in from the modem or peripheral: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a synchronizer. The block then reports the line's present asserted level, and it keeps a sticky flag that records whether the line has changed since the CPU last read the word. Any raised flag drives an interrupt request to the CPU.

The CPU reads the word by pulsing a single read-enable. The word on the read-data output is combinational. During the read cycle it shows the flags exactly as they stand, and the clock edge that ends the read clears them. A change that the edge detector finds on that same edge is kept. The flag for the ring line is raised only when the ring signal ends, that is, when the input returns from low to high. Bit 8 repeats the flow-control-mode setting, which the companion control register provides on an input.

Top module: `modem_status_reg`

## Requirements
- R1: Bit 0 (clear-to-send change) becomes 1 when `modem_n_i[0]` changes in either direction, and stays 1 until a read.
- R2: Bit 1 (data-set-ready change) becomes 1 when `modem_n_i[1]` changes in either direction.
- R3: Bit 2 (ring end) becomes 1 only when `modem_n_i[2]` goes from 0 to 1. A change from 1 to 0 leaves it 0.
- R4: Bit 3 (carrier change) becomes 1 when `modem_n_i[3]` changes in either direction.
- R5: During a cycle with `rd_en_i` high, `rd_data_o` shows the current flags. After that clock edge, bits 3:0 are 0 unless a new change was detected on that edge.
- R6: `irq_o` is 1 exactly when any of bits 3:0 of `rd_data_o` is 1.
- R7: Bits 4, 5, 6 and 7 are the inverted levels of `modem_n_i[0]`, `[1]`, `[2]` and `[3]`. They follow an input change after two clock edges. A flag follows the change after three clock edges.
- R8: Bit 8 equals `fc_mode_i`, and bits 31:9 always read 0.
- R9: A flag stays at 1 through any number of further changes and idle cycles until a read clears it.
- R10: If a change is detected on the same edge that ends a read, that line's flag is 1 after the edge. Flags that had no change on that edge are cleared.
- R11: While reset is held and after reset is released, all flags are 0 and `irq_o` is 0. The input levels present at reset produce no flag, even when lines are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| modem_n_i | input | 4 | Raw active-low lines: [0] clear-to-send, [1] data-set-ready, [2] ring, [3] carrier detect |
| fc_mode_i | input | 1 | Flow-control-mode bit from the modem control register |
| rd_en_i | input | 1 | Register read strobe; flags clear on the edge that ends it |
| rd_data_o | output | 32 | Status word |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The stimulus table asserts and releases each line one at a time, in both directions. This separates both-edge flags from the ring line's rising-only flag, and it confirms which inverted level lands in which bit. Two rows flip several lines at once with mixed directions, which would expose any cross-wiring between lines. Directed cases time a change to land on the edge of a read, to show that set beats clear. They repeat changes without a read, to show that the flags are sticky. They step one cycle at a time after a change, to pin the two-edge and three-edge latencies. They also reset the block with every line asserted, to show that a reset produces no spurious flag.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int unsigned LINE_CNT = 4;

    // line positions inside the 4-bit input bus
    localparam int unsigned LN_CTS  = 0;
    localparam int unsigned LN_DSR  = 1;
    localparam int unsigned LN_RING = 2;
    localparam int unsigned LN_DCD  = 3;

    // field positions inside the status word
    localparam int unsigned FLAG_LSB  = 0;
    localparam int unsigned LEVEL_LSB = FLAG_LSB + LINE_CNT;
    localparam int unsigned FCM_POS   = LEVEL_LSB + LINE_CNT;
    localparam int unsigned USED_BITS = FCM_POS + 1;

    typedef logic [LINE_CNT-1:0] line_vec_t;

    // per-line selection of the edge that raises the flag
    typedef enum logic [1:0] {
        EDGE_BOTH   = 2'd0,
        EDGE_RISING = 2'd1
    } edge_mode_e;

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int unsigned WIDTH     = 4,
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{chain: {STAGES{{WIDTH{RESET_VAL}}}}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/msr_edge.sv
module msr_edge #(
    parameter int unsigned WIDTH        = 4,
    parameter int unsigned PRIME_CYCLES = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    localparam int unsigned CNT_W = $clog2(PRIME_CYCLES + 1);
    localparam logic [CNT_W-1:0] ARMED_AT = CNT_W'(PRIME_CYCLES);

    typedef struct packed {
        logic [WIDTH-1:0] hist;
        logic [CNT_W-1:0] prime;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        armed;

    assign armed = (st_q.prime == ARMED_AT);

    always_comb begin
        st_d      = st_q;
        st_d.hist = level_i;
        if (!armed) begin
            st_d.prime = st_q.prime + CNT_W'(1);
        end
    end

    // history follows the level every cycle; edges are reported once primed
    assign rise_o = armed ? (level_i & ~st_q.hist) : '0;
    assign fall_o = armed ? (~level_i & st_q.hist) : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{hist: '1, prime: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [3:0]        modem_n_i,
    input  logic              fc_mode_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);

    import msr_pkg::*;

    localparam int unsigned PRIME  = SYNC_STAGES + 1;
    localparam int unsigned PAD_W  = DATA_W - USED_BITS;

    localparam edge_mode_e LINE_MODE [LINE_CNT] = '{
        EDGE_BOTH, EDGE_BOTH, EDGE_RISING, EDGE_BOTH
    };

    typedef struct packed {
        line_vec_t flags;
    } stat_state_t;

    line_vec_t   line_sync;
    line_vec_t   line_rise;
    line_vec_t   line_fall;
    line_vec_t   line_set;
    stat_state_t st_d, st_q;

    msr_sync #(
        .WIDTH     (LINE_CNT),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (modem_n_i),
        .sync_o  (line_sync)
    );

    msr_edge #(
        .WIDTH        (LINE_CNT),
        .PRIME_CYCLES (PRIME)
    ) u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (line_sync),
        .rise_o  (line_rise),
        .fall_o  (line_fall)
    );

    for (genvar g = 0; g < int'(LINE_CNT); g++) begin : g_line
        if (LINE_MODE[g] == EDGE_RISING) begin : g_rise_only
            assign line_set[g] = line_rise[g];
        end else begin : g_both
            assign line_set[g] = line_rise[g] | line_fall[g];
        end
    end

    // set wins over the clear that a read applies
    always_comb begin
        st_d = st_q;
        if (rd_en_i) begin
            st_d.flags = '0;
        end
        st_d.flags = st_d.flags | line_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{flags: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = {{PAD_W{1'b0}}, fc_mode_i, ~line_sync, st_q.flags};
    assign irq_o     = |st_q.flags;

endmodule

// File: rtl/modem_status_reg_chk.sv
module modem_status_reg_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        rd_en_i,
    input logic [3:0]  set_vec,
    input logic [31:0] rd_data,
    input logic        irq
);

    a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && set_vec == 4'b0) |=> (rd_data[3:0] == 4'b0));

    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_vec != 4'b0) |=> ((rd_data[3:0] & $past(set_vec)) == $past(set_vec)));

    a_r9_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_en_i && set_vec == 4'b0) |=> $stable(rd_data[3:0]));

    a_r6_irq_any_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq == (rd_data[3:0] != 4'b0));

    a_r3_ring_trailing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_data[2]) |-> ($past(rd_data[6]) == 1'b0 && $past(rd_data[6], 2) == 1'b1));

    a_r8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data[31:9] == 23'b0);

endmodule

bind modem_status_reg modem_status_reg_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .set_vec (line_set),
    .rd_data (rd_data_o),
    .irq     (irq_o)
);

// File: tb/modem_status_reg_bench.sv
module modem_status_reg_bench;

    localparam int NVEC  = 8;
    localparam int WATCH = 20000;

    // {lines[3:0], fc, expected[8:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {4'b1110, 1'b0, 9'h011},
        {4'b1111, 1'b0, 9'h001},
        {4'b1011, 1'b0, 9'h040},
        {4'b1111, 1'b0, 9'h004},
        {4'b1101, 1'b1, 9'h122},
        {4'b0101, 1'b1, 9'h1A8},
        {4'b1010, 1'b0, 9'h05B},
        {4'b1111, 1'b0, 9'h005}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  lines_n;
    logic        fc;
    logic        rd;
    logic [31:0] rdata;
    logic        irq;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 1'b0;

    always #10 clk = ~clk;

    modem_status_reg u_modem_status_reg (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .modem_n_i (lines_n),
        .fc_mode_i (fc),
        .rd_en_i   (rd),
        .rd_data_o (rdata),
        .irq_o     (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:    return "R1 clear-to-send change";
            2:       return "R3 ring falling ignored";
            3:       return "R3 ring trailing edge";
            4:       return "R2 data-set-ready change + R8 fc bit";
            5:       return "R4 carrier change + R7 levels";
            default: return "R7 multi-line mixed change";
        endcase
    endfunction

    task automatic read_and_clear(input string tag, input logic [31:0] exp);
        rd = 1'b1;
        #1;
        check({tag, " R5 data during read"}, rdata, exp);
        @(negedge clk);
        rd = 1'b0;
        check({tag, " R5 flags cleared"}, {28'b0, rdata[3:0]}, 32'b0);
        check({tag, " R6 irq after clear"}, {31'b0, irq}, 32'b0);
    endtask

    initial begin
        repeat (WATCH) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        lines_n = 4'hF;
        fc      = 1'b0;
        rd      = 1'b0;
        wait_n(3);
        check("R11 word in reset", rdata, 32'h0);
        check("R11 irq in reset", {31'b0, irq}, 32'b0);
        rst_n = 1'b1;
        wait_n(6);
        check("R11 word after reset idle", rdata, 32'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            lines_n = VEC[i][13:10];
            fc      = VEC[i][9];
            wait_n(4);
            check(vec_tag(i), rdata, {23'b0, VEC[i][8:0]});
            check({vec_tag(i), " R6 irq"}, {31'b0, irq}, {31'b0, |VEC[i][3:0]});
            read_and_clear(vec_tag(i), {23'b0, VEC[i][8:0]});
        end

        // R9 sticky: two changes, long idle, no read
        fc = 1'b0;
        lines_n = 4'b1110;
        wait_n(4);
        lines_n = 4'b1111;
        wait_n(4);
        check("R9 sticky after two changes", rdata, 32'h001);
        wait_n(10);
        check("R9 sticky after idle", rdata, 32'h001);
        read_and_clear("R9", 32'h001);

        // R10 change lands on the edge that ends a read
        lines_n = 4'b0111;
        wait_n(4);
        check("R10 setup carrier flag", rdata, 32'h088);
        lines_n = 4'b0110;
        wait_n(2);
        rd = 1'b1;
        #1;
        check("R10 data during read", rdata, 32'h098);
        @(negedge clk);
        rd = 1'b0;
        check("R10 set wins over clear", rdata, 32'h091);
        read_and_clear("R10", 32'h091);

        // R11 reset with all lines asserted
        rst_n   = 1'b0;
        lines_n = 4'b0000;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(6);
        check("R11 no flag from asserted lines", rdata, 32'h0F0);
        check("R11 irq quiet", {31'b0, irq}, 32'b0);

        // R7 latency: levels after two edges, flag after three
        lines_n = 4'b1000;
        wait_n(1);
        check("R7 level unchanged after one edge", rdata, 32'h0F0);
        wait_n(1);
        check("R7 level after two edges", rdata, 32'h070);
        wait_n(1);
        check("R4 flag after three edges", rdata, 32'h078);
        read_and_clear("R4 latency", 32'h078);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule